// File: doc/BRIEF.md
# Coupled-Phase Skew Correction Engine

This block corrects the sampling-instant skew of a small set of interleaved converter channels. On each decimated calibration tick it takes one estimated phase per channel, forms the sine of every pairwise phase difference, and moves each channel's phase-correction word by a scaled average of those sines. Every channel is coupled to every other, and there is no free-running frequency term because all channels share one clock. Repeated ticks pull the channel phases toward a common value, like a population of coupled oscillators locking together.

The sines come from one iterative shift-and-add rotation unit per channel pair, so the datapath has no multiplier and no sine table. Each pairwise sine is computed once. It is added to the lower-numbered channel of the pair and subtracted from the other. The coupling strength is given as a power-of-two exponent, so scaling is also a shift. Along with the correction words, the block gives a squared coherence figure: 1.0 when all channels agree and near 0 when they are spread evenly around the circle. A one-cycle completion flag marks each finished update.

Top module: `kuramoto_phase_engine`

## Requirements
- R1: While reset is active and after reset is released, every correction word is 0, `done_o` is 0 and `coherence_o` is 0.
- R2: When `tick_i` is high at a rising edge and no update is in progress, that edge starts an update. The new correction words appear after rising edge number ITER+1 counted from that edge, which is the 15th with defaults. Until then the words keep their old values.
- R3: `done_o` is high for exactly one cycle. It rises one edge after the correction words are written, so it is first seen after edge ITER+2 of the update.
- R4: Channel c occupies bits [16c+15:16c] of `est_phase_i` and `dly_word_o`. Values are two's-complement Q3.13 radians. Take S_c as the sum over all other channels j of sin(est_j − est_c), in units of 2^-13. An update adds floor(S_c / 2^(k+MU_SHIFT+log2 N)) to word c, within ±3 LSB. Here k is `k_shift_i` and MU_SHIFT defaults to 1.
- R5: A phase difference beyond ±π is wrapped into that range before the sine is formed. Channel phases near +π and near −π therefore produce the small sine of their true angular separation.
- R6: A larger `k_shift_i` gives proportionally smaller corrections. k = 0 means unit coupling, and each step of k halves the coupling.
- R7: A correction word saturates at +32767 and −32768 instead of wrapping.
- R8: The phases and `k_shift_i` are captured at the starting edge. A `tick_i` seen while an update is in progress is ignored, and so are input changes during the update. Such a tick produces no second `done_o` and no second change of the words.
- R9: `coherence_o` is written on the same edge as the words. Its value is (N + 2·Σ_pairs cos(est_j − est_i)) / N² in Q3.13, clamped at 0, within ±8 LSB. Equal phases give 8192.
- R10: Between updates the correction words hold their values and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Decimated calibration strobe |
| est_phase_i | input | N_CH*W | Estimated phase per channel, Q3.13 radians, channel 0 in the low bits |
| k_shift_i | input | KSW | Coupling exponent; coupling strength is 2^-k |
| dly_word_o | output | N_CH*W | Per-channel delay-line correction words, Q3.13 |
| done_o | output | 1 | One-cycle pulse after an update's words are written |
| coherence_o | output | W | Squared order parameter, Q3.13 |

## Verification
The bench builds the engine with its defaults: four channels, 16-bit Q3.13 phases, 14 rotation steps and a step-size shift of 1. With four channels, six pair units work at once, so every channel's sum mixes added and subtracted terms. The 16-bit words let a run of about forty unit-coupling ticks push one channel into positive saturation and others into negative saturation. The reference model computes sines and cosines in floating point from the same quantised phases. It compares the words, the flag and the coherence on every clock of each update window. It also drives phase pairs that straddle ±π and ticks that arrive during an update.

// File: rtl/kpe_pkg.sv
package kpe_pkg;
   // Angle constants kept at 30 fractional bits, rescaled per instance.
   localparam int     ANG_FRAC = 30;
   localparam longint PI_Q30   = 64'sd3373259426;
   localparam longint KINV_Q30 = 64'sd652032874;

   function automatic longint atan_q30(input int idx);
      case (idx)
         0:  return 64'sd843314857;
         1:  return 64'sd497837829;
         2:  return 64'sd263043838;
         3:  return 64'sd133525159;
         4:  return 64'sd67021687;
         5:  return 64'sd33543516;
         6:  return 64'sd16775851;
         7:  return 64'sd8388437;
         8:  return 64'sd4194283;
         9:  return 64'sd2097149;
         10: return 64'sd1048576;
         11: return 64'sd524288;
         12: return 64'sd262144;
         13: return 64'sd131072;
         default: return 64'sd0;
      endcase
   endfunction

   function automatic longint rescale(input longint v, input int frac);
      return (v + (longint'(1) <<< (ANG_FRAC - frac - 1))) >>> (ANG_FRAC - frac);
   endfunction
endpackage

// File: rtl/kpe_cordic.sv
module kpe_cordic #(
   parameter int W    = 16,
   parameter int FRAC = 13,
   parameter int ITER = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [W-1:0]        a_i,
   input  logic [W-1:0]        b_i,
   output logic signed [W-1:0] sin_o,
   output logic signed [W-1:0] cos_o,
   output logic                valid_o
);
   localparam int ZW   = W + 1;
   localparam int GF   = FRAC + 2;
   localparam int IW   = FRAC + 5;
   localparam int CNTW = $clog2(ITER);
   localparam logic signed [ZW-1:0] PI_Z   = ZW'(kpe_pkg::rescale(kpe_pkg::PI_Q30, FRAC));
   localparam logic signed [ZW-1:0] TWOPI  = ZW'(2 * kpe_pkg::rescale(kpe_pkg::PI_Q30, FRAC));
   localparam logic signed [ZW-1:0] HALFPI = ZW'(kpe_pkg::rescale(kpe_pkg::PI_Q30 / 2, FRAC));
   localparam logic signed [IW-1:0] KPOS   = IW'(kpe_pkg::rescale(kpe_pkg::KINV_Q30, GF));
   localparam logic signed [IW-1:0] KNEG   = -KPOS;
   localparam logic signed [IW-1:0] RND    = 2;
   localparam logic [CNTW-1:0]      LAST   = CNTW'(ITER - 1);

   logic signed [ZW-1:0] atan_v [2**CNTW];
   for (genvar g = 0; g < 2**CNTW; g++) begin : g_atan
      assign atan_v[g] = (g < ITER) ? ZW'(kpe_pkg::rescale(kpe_pkg::atan_q30(g), FRAC)) : '0;
   end

   logic signed [ZW-1:0] raw_d, wrap_d, z_init;
   logic signed [IW-1:0] x_init;
   always_comb begin
      raw_d = $signed({b_i[W-1], b_i}) - $signed({a_i[W-1], a_i});
      if (raw_d > PI_Z)        wrap_d = raw_d - TWOPI;
      else if (raw_d < -PI_Z)  wrap_d = raw_d + TWOPI;
      else                     wrap_d = raw_d;
      if (wrap_d > HALFPI)       begin z_init = wrap_d - PI_Z; x_init = KNEG; end
      else if (wrap_d < -HALFPI) begin z_init = wrap_d + PI_Z; x_init = KNEG; end
      else                       begin z_init = wrap_d;        x_init = KPOS; end
   end

   logic signed [IW-1:0] x_q, y_q, x_n, y_n;
   logic signed [ZW-1:0] z_q, z_n;
   logic [CNTW-1:0]      cnt_q;
   logic                 run_q, valid_q;

   always_comb begin
      if (z_q[ZW-1]) begin
         x_n = x_q + (y_q >>> cnt_q);
         y_n = y_q - (x_q >>> cnt_q);
         z_n = z_q + atan_v[cnt_q];
      end else begin
         x_n = x_q - (y_q >>> cnt_q);
         y_n = y_q + (x_q >>> cnt_q);
         z_n = z_q - atan_v[cnt_q];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0; y_q <= '0; z_q <= '0;
         cnt_q <= '0; run_q <= 1'b0; valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (start_i) begin
            x_q <= x_init; y_q <= '0; z_q <= z_init;
            cnt_q <= '0; run_q <= 1'b1;
         end else if (run_q) begin
            x_q <= x_n; y_q <= y_n; z_q <= z_n;
            cnt_q <= cnt_q + CNTW'(1);
            if (cnt_q == LAST) begin
               run_q   <= 1'b0;
               valid_q <= 1'b1;
            end
         end
      end
   end

   logic signed [IW-1:0] x_rnd, y_rnd;
   assign x_rnd   = (x_q + RND) >>> 2;
   assign y_rnd   = (y_q + RND) >>> 2;
   assign sin_o   = W'(y_rnd);
   assign cos_o   = W'(x_rnd);
   assign valid_o = valid_q;

   AST_REDUCED_ANGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (z_q <= HALFPI && z_q >= -HALFPI)); // R5
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !run_q); // R8
   AST_RESIDUAL: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (z_q <= 8 && z_q >= -8)); // R4
endmodule

// File: rtl/kpe_chan_acc.sv
module kpe_chan_acc #(
   parameter int N        = 4,
   parameter int W        = 16,
   parameter int MU_SHIFT = 1,
   parameter int KSW      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [N*W-1:0]      row_i,
   input  logic [KSW-1:0]      k_shift_i,
   output logic signed [W-1:0] word_o
);
   localparam int LOG2N = $clog2(N);
   localparam int SW    = W + LOG2N + 1;
   localparam logic signed [SW:0]  MAXV = (SW+1)'((1 << (W-1)) - 1);
   localparam logic signed [SW:0]  MINV = -MAXV - 1;
   localparam logic signed [W-1:0] MAXW = W'((1 << (W-1)) - 1);

   logic signed [SW-1:0] acc, delta;
   logic signed [SW:0]   sum_n;
   logic signed [W-1:0]  word_q, word_n;

   always_comb begin
      acc = '0;
      for (int j = 0; j < N; j++) acc = acc + SW'($signed(row_i[j*W +: W]));
      delta = acc >>> (int'(k_shift_i) + MU_SHIFT + LOG2N);
      sum_n = (SW+1)'(delta) + (SW+1)'(word_q);
      if (sum_n > MAXV)      word_n = MAXW;
      else if (sum_n < MINV) word_n = -MAXW - 1;
      else                   word_n = W'(sum_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (wr_i) word_q <= word_n;
   end

   assign word_o = word_q;

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && word_q == MAXW && !delta[SW-1]) |=> word_q == MAXW); // R7
endmodule

// File: rtl/kuramoto_phase_engine.sv
module kuramoto_phase_engine #(
   parameter int N_CH     = 4,
   parameter int W        = 16,
   parameter int FRAC     = 13,
   parameter int ITER     = 14,
   parameter int MU_SHIFT = 1,
   parameter int KSW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [N_CH*W-1:0] est_phase_i,
   input  logic [KSW-1:0]    k_shift_i,
   output logic [N_CH*W-1:0] dly_word_o,
   output logic              done_o,
   output logic [W-1:0]      coherence_o
);
   localparam int NPAIR = N_CH * (N_CH - 1) / 2;
   localparam int LOG2N = $clog2(N_CH);
   localparam int ONE   = 1 << FRAC;
   localparam int CSW   = W + $clog2(NPAIR) + 2;

   if (N_CH < 2 || (N_CH & (N_CH - 1)) != 0) begin : g_bad_n
      $error("N_CH must be a power of two of at least 2");
   end
   if (W - FRAC < 3) begin : g_bad_w
      $error("W must leave three integer bits above FRAC");
   end
   if (ITER < 10 || ITER > 14) begin : g_bad_iter
      $error("ITER must lie in 10..14");
   end
   if (FRAC < 8 || FRAC > 27) begin : g_bad_frac
      $error("FRAC must lie in 8..27");
   end

   logic                busy_q, wr_q, done_q, start, all_valid;
   logic [KSW-1:0]      k_q;
   logic [NPAIR-1:0]    vld;
   logic signed [W-1:0] cos_p [NPAIR];
   logic [N_CH*W-1:0]   row   [N_CH];

   assign start     = tick_i && !busy_q;
   assign all_valid = &vld;

   for (genvar i = 0; i < N_CH; i++) begin : g_i
      for (genvar j = 0; j < N_CH; j++) begin : g_j
         if (j > i) begin : g_pair
            localparam int P = i*N_CH - (i*(i+1))/2 + (j-i-1);
            logic signed [W-1:0] s_w;
            kpe_cordic #(.W(W), .FRAC(FRAC), .ITER(ITER)) u_cordic (
               .clk(clk), .rst_n(rst_n), .start_i(start),
               .a_i(est_phase_i[i*W +: W]), .b_i(est_phase_i[j*W +: W]),
               .sin_o(s_w), .cos_o(cos_p[P]), .valid_o(vld[P]));
            assign row[i][j*W +: W] = s_w;
            assign row[j][i*W +: W] = -s_w;
         end else if (j == i) begin : g_diag
            assign row[i][i*W +: W] = '0;
         end
      end
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic signed [W-1:0] w_c;
      kpe_chan_acc #(.N(N_CH), .W(W), .MU_SHIFT(MU_SHIFT), .KSW(KSW)) u_acc (
         .clk(clk), .rst_n(rst_n), .wr_i(all_valid), .row_i(row[c]),
         .k_shift_i(k_q), .word_o(w_c));
      assign dly_word_o[c*W +: W] = w_c;
   end

   logic signed [CSW-1:0] csum, ctot, cscl;
   logic [W-1:0]          coh_n, coh_q;
   always_comb begin
      csum = '0;
      for (int p = 0; p < NPAIR; p++) csum = csum + CSW'(cos_p[p]);
      ctot  = CSW'(N_CH * ONE) + (csum <<< 1);
      cscl  = ctot >>> (2 * LOG2N);
      coh_n = cscl[CSW-1] ? '0 : W'(cscl);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; wr_q <= 1'b0; done_q <= 1'b0;
         k_q <= '0; coh_q <= '0;
      end else begin
         wr_q   <= all_valid;
         done_q <= wr_q;
         if (start) begin
            busy_q <= 1'b1;
            k_q    <= k_shift_i;
         end else if (all_valid) begin
            busy_q <= 1'b0;
         end
         if (all_valid) coh_q <= coh_n;
      end
   end

   assign done_o      = done_q;
   assign coherence_o = coh_q;

   AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !all_valid |=> $stable(dly_word_o)); // R10
   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      all_valid |=> ##1 done_o); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R3
   AST_COH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !all_valid |=> $stable(coherence_o)); // R9
endmodule

// File: tb/test_kuramoto_phase_engine.sv
module test_kuramoto_phase_engine;
   localparam int N    = 4;
   localparam int W    = 16;
   localparam int ITER = 14;
   localparam int MU   = 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic [N*W-1:0] est = '0;
   logic [3:0]   ksh = '0;
   logic [N*W-1:0] dly;
   logic         done;
   logic [W-1:0] coh;

   int nvec = 0;
   int nbad = 0;
   int mdl [N];

   always #5 clk = ~clk;

   kuramoto_phase_engine i_kuramoto_phase_engine (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .est_phase_i(est),
      .k_shift_i(ksh), .dly_word_o(dly), .done_o(done), .coherence_o(coh));

   function automatic int qph(input real r);
      return $rtoi(r * 8192.0 + ((r >= 0.0) ? 0.5 : -0.5));
   endfunction

   function automatic int word(input int c);
      return int'($signed(dly[c*W +: W]));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic run_upd(input int ph [N], input int k, input bit inject);
      int  ex [N];
      bit  clamped [N];
      real s, cs, pw;
      int  ecoh;
      pw = 1.0;
      for (int b = 0; b < k + MU + 2; b++) pw = pw * 2.0;
      cs = 0.0;
      for (int c = 0; c < N; c++) begin
         s = 0.0;
         for (int j = 0; j < N; j++)
            if (j != c) s = s + $sin(real'(ph[j] - ph[c]) / 8192.0) * 8192.0;
         ex[c] = mdl[c] + $rtoi($floor(s / pw));
         clamped[c] = 1'b0;
         if (ex[c] > 32767)  begin ex[c] = 32767;  clamped[c] = 1'b1; end
         if (ex[c] < -32768) begin ex[c] = -32768; clamped[c] = 1'b1; end
         for (int j = c + 1; j < N; j++) cs = cs + $cos(real'(ph[j] - ph[c]) / 8192.0);
      end
      ecoh = $rtoi((4.0 + 2.0 * cs) / 16.0 * 8192.0);
      if (ecoh < 0) ecoh = 0;

      @(negedge clk);
      for (int c = 0; c < N; c++) est[c*W +: W] = 16'(ph[c]);
      ksh  = 4'(k);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      for (int cy = 0; cy <= ITER + 3; cy++) begin
         chk(done == (cy == ITER + 2), "R3 done timing", int'(done), int'(cy == ITER + 2));
         if (cy <= ITER) begin
            for (int c = 0; c < N; c++)
               chk(word(c) == mdl[c], "R2 word before write", word(c), mdl[c]);
         end else if (cy == ITER + 1) begin
            for (int c = 0; c < N; c++) begin
               if (clamped[c])
                  chk(iabs(word(c) - ex[c]) <= 3 && (word(c) > 0) == (ex[c] > 0),
                      "R7 saturation", word(c), ex[c]);
               else
                  chk(iabs(word(c) - ex[c]) <= 3, "R4 update law", word(c), ex[c]);
               mdl[c] = word(c);
            end
            chk(iabs(int'(coh) - ecoh) <= 8, "R9 coherence", int'(coh), ecoh);
         end else begin
            for (int c = 0; c < N; c++)
               chk(word(c) == mdl[c], "R10 word hold", word(c), mdl[c]);
         end
         if (inject && cy == 3) begin
            tick = 1'b1;
            for (int c = 0; c < N; c++) est[c*W +: W] = 16'(qph(1.5) * (c - 1));
            ksh = 4'd7;
         end
         if (inject && cy == 4) tick = 1'b0;
         @(negedge clk);
      end
      if (inject) begin
         for (int cy = 0; cy < ITER + 4; cy++) begin
            chk(done == 1'b0, "R8 no second done", int'(done), 0);
            for (int c = 0; c < N; c++)
               chk(word(c) == mdl[c], "R8 no second write", word(c), mdl[c]);
            @(negedge clk);
         end
      end
   endtask

   task automatic idle(input int n);
      for (int cy = 0; cy < n; cy++) begin
         @(negedge clk);
         chk(done == 1'b0, "R10 idle done", int'(done), 0);
         for (int c = 0; c < N; c++)
            chk(word(c) == mdl[c], "R10 idle hold", word(c), mdl[c]);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin : main
      int ph [N];
      for (int c = 0; c < N; c++) mdl[c] = 0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      for (int c = 0; c < N; c++) chk(word(c) == 0, "R1 reset word", word(c), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(coh == '0, "R1 reset coherence", int'(coh), 0);
      for (int c = 0; c < N; c++) chk(word(c) == 0, "R1 word after release", word(c), 0);
      idle(4);

      ph = '{qph(0.2), qph(-0.1), qph(0.5), qph(-0.4)};
      run_upd(ph, 0, 1'b0);            // R4 unit coupling
      idle(3);
      run_upd(ph, 3, 1'b0);            // R6 weaker coupling
      ph = '{qph(3.0), qph(-3.0), qph(2.9), qph(-2.8)};
      run_upd(ph, 1, 1'b0);            // R5 wrap across +/-pi
      ph = '{qph(1.1), qph(1.1), qph(1.1), qph(1.1)};
      run_upd(ph, 0, 1'b0);            // R9 aligned gives 8192
      chk(iabs(int'(coh) - 8192) <= 8, "R9 aligned coherence", int'(coh), 8192);
      ph = '{qph(0.0), qph(1.5708), qph(3.1416), qph(-1.5708)};
      run_upd(ph, 2, 1'b0);            // R9 evenly spread
      ph = '{qph(-0.7), qph(0.3), qph(0.9), qph(-1.2)};
      run_upd(ph, 1, 1'b1);            // R8 tick and inputs ignored while busy
      ph = '{qph(0.0), qph(1.0), qph(1.0), qph(1.0)};
      for (int u = 0; u < 42; u++) run_upd(ph, 0, 1'b0);  // R7 saturation both ways
      chk(word(0) == 32767, "R7 positive rail", word(0), 32767);
      chk(word(1) == -32768, "R7 negative rail", word(1), -32768);
      idle(5);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule